// File: doc/BRIEF.md
# Precise Exception Commit Controller

This block tracks faults for a five-stage in-order pipeline with fetch, decode, execute, memory and writeback stages. Every instruction in flight carries a small record with it: a valid bit, a fault bit, a cause code, its own PC, a delay-slot flag and the PC that follows it. Faults come in as plain inputs from fetch (translation), execute (arithmetic) and memory (data translation). They are only recorded in that record. Nothing is acted on until the instruction reaches writeback. Because the pipe always advances in order, the first faulting record to reach writeback is always the oldest fault, even when a younger instruction raised its fault earlier in time.

When a faulting record reaches writeback, the block does four things. It suppresses that instruction's writes. It saves the record's PC, its following PC and its slot flag into the exception registers. It loads the handler vector into the fetch PC and enters supervisor mode. It squashes every younger instruction. An interrupt request in user mode replaces the instruction being fetched with a faulting no-op that carries that instruction's PC. A return input in supervisor mode does the reverse of a trap: it restarts fetch at the saved PC, and when that PC was a delay slot it resumes at the saved following PC. The block also owns the fetch PC. That PC steps by one instruction per cycle and follows taken branches that are resolved in decode, behind a single delay slot.

Top module: `precise_exc_commit`

## Requirements
- R1: While reset is low, fetchPc equals RESET_PC (0x1000 by default), superMode is 0, and trap and wbCommit are 0.
- R2: With no redirect, fetchPc advances by INSN_BYTES (4) every cycle. An instruction fetched in cycle c reaches writeback in cycle c+4. wbCommit is then high with wbPc equal to its PC, in program order.
- R3: A fault raised by ifFault (fetch), exFault (execute) or memFault (memory) against an instruction is not acted on until that instruction reaches writeback. In that cycle trap is high. excCause encodes the cause: 1 interrupt, 2 fetch translation, 3 arithmetic, 4 data translation.
- R4: In the cycle after trap, epc holds the trapping instruction's PC, fetchPc equals VECTOR (0x180 by default) and superMode is 1.
- R5: A faulting instruction never commits: wbCommit is low while trap is high. memWriteOk is low when the memory-stage instruction carries a fault, raises memFault, or is younger than a trapping instruction.
- R6: All younger instructions are squashed. wbCommit stays low for the four cycles after trap, and the next commit is the handler instruction at VECTOR.
- R7: When several in-flight instructions fault, only the oldest traps, even if a younger one raised its fault earlier in time. The squashed younger faults cause no later trap.
- R8: When one instruction faults in more than one stage, excCause reports the earliest stage's cause.
- R9: With intReq high in user mode, the instruction in fetch is replaced by a faulting no-op that carries its PC and cause 1. In supervisor mode intReq has no effect.
- R10: An instruction fetched while decode holds a valid, non-faulting branch (idBranch) is a delay slot. On a trap from it, epcSlot is 1 and epcNext is idTarget if idTaken was high, or its PC+4 if not. For any other instruction, epcSlot is 0 and epcNext is PC+4.
- R11: A taken branch in decode loads fetchPc with idTarget on the next cycle, after the delay slot has been fetched. A not-taken branch leaves the sequence unchanged.
- R12: eret in supervisor mode loads fetchPc with epc, clears superMode and squashes the pipe. If epcSlot is 1, the fetch after that comes from epcNext. eret in user mode has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ifFault | input | 1 | Translation fault on the instruction now in fetch |
| exFault | input | 1 | Arithmetic fault on the instruction now in execute |
| memFault | input | 1 | Translation fault on the instruction now in memory |
| intReq | input | 1 | External interrupt request, level |
| eret | input | 1 | Return from exception |
| idBranch | input | 1 | Decode stage holds a branch |
| idTaken | input | 1 | Branch in decode is taken |
| idTarget | input | PC_W | Target of the branch in decode |
| fetchPc | output | PC_W | Current fetch PC |
| wbCommit | output | 1 | Writeback instruction may write architectural state |
| wbPc | output | PC_W | PC of the writeback instruction |
| memWriteOk | output | 1 | Memory-stage instruction may write memory |
| trap | output | 1 | Exception taken this cycle |
| epc | output | PC_W | Saved exception PC |
| epcNext | output | PC_W | Saved following PC |
| epcSlot | output | 1 | Saved instruction was in a delay slot |
| excCause | output | 3 | Saved cause code |
| superMode | output | 1 | Supervisor mode flag |

## Verification
A stage record that loses its fault bit shows up four cycles after the fault is raised: a commit appears at wbPc where a trap was due, or the trap arrives late with the wrong epc. A lost or stale slot flag or following PC only shows up on return. In that case the fetch two cycles after eret goes to the wrong address. A flush that misses a stage lets a squashed PC commit inside the four-cycle window after trap. A cause that is overwritten rather than kept is seen in excCause one cycle after the trap.

// File: rtl/pexc_pkg.sv
package pexc_pkg;

  typedef enum logic [2:0] {
    CAUSE_NONE   = 3'd0,
    CAUSE_INT    = 3'd1,
    CAUSE_IFETCH = 3'd2,
    CAUSE_ARITH  = 3'd3,
    CAUSE_DATA   = 3'd4
  } cause_e;

  // strobes from control to datapath
  typedef struct packed {
    logic takeTrap;
    logic takeRet;
    logic flush;
    logic insertInt;
    logic useAlt;
  } strobe_t;

endpackage

// File: rtl/pexc_ctrl.sv
module pexc_ctrl
  import pexc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    wbValid,
  input  logic    wbFault,
  input  logic    intReq,
  input  logic    eret,
  input  logic    epcSlot,
  output strobe_t st,
  output logic    superMode
);

  logic resumeAlt;
  logic trapNow;
  logic retNow;

  assign trapNow = wbValid & wbFault;
  // trap wins over a return arriving in the same cycle
  assign retNow  = eret & superMode & ~trapNow;

  always_comb begin
    st.takeTrap  = trapNow;
    st.takeRet   = retNow;
    st.flush     = trapNow | retNow;
    st.insertInt = intReq & ~superMode & ~(trapNow | retNow);
    st.useAlt    = resumeAlt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      superMode <= 1'b0;
      resumeAlt <= 1'b0;
    end else begin
      if (trapNow)     superMode <= 1'b1;
      else if (retNow) superMode <= 1'b0;
      // second step of a return into a delay slot
      resumeAlt <= retNow & epcSlot;
    end
  end

endmodule

// File: rtl/pexc_dp.sv
module pexc_dp
  import pexc_pkg::*;
#(
  parameter int unsigned PC_W       = 32,
  parameter int unsigned INSN_BYTES = 4,
  parameter int unsigned VECTOR     = 32'h0000_0180,
  parameter int unsigned RESET_PC   = 32'h0000_1000
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         st,
  input  logic            ifFault,
  input  logic            exFault,
  input  logic            memFault,
  input  logic            idBranch,
  input  logic            idTaken,
  input  logic [PC_W-1:0] idTarget,
  output logic [PC_W-1:0] fetchPc,
  output logic            wbValid,
  output logic            wbFault,
  output logic [PC_W-1:0] wbPc,
  output logic            wbCommit,
  output logic            memWriteOk,
  output logic [PC_W-1:0] epc,
  output logic [PC_W-1:0] epcNext,
  output logic            epcSlot,
  output cause_e          excCause
);

  localparam int NST   = 4;   // decode, execute, memory, writeback
  localparam int ID_S  = 1;
  localparam int EX_S  = 2;
  localparam int MEM_S = 3;
  localparam int WB_S  = NST;
  localparam logic [PC_W-1:0] STEP   = PC_W'(INSN_BYTES);
  localparam logic [PC_W-1:0] VEC_PC = PC_W'(VECTOR);
  localparam logic [PC_W-1:0] RST_PC = PC_W'(RESET_PC);

  typedef struct packed {
    logic            vld;
    logic            flt;
    cause_e          cs;
    logic            slot;
    logic [PC_W-1:0] pc;
    logic [PC_W-1:0] alt;
  } stage_t;

  // index 0 is the record being formed in fetch
  stage_t pipe [0:NST];

  logic brInId;
  logic brTake;
  logic [PC_W-1:0] seqPc;
  logic [PC_W-1:0] nextPc;

  assign brInId = idBranch & pipe[ID_S].vld & ~pipe[ID_S].flt;
  assign brTake = brInId & idTaken;
  assign seqPc  = fetchPc + STEP;

  always_comb begin
    pipe[0].vld  = 1'b1;
    pipe[0].flt  = st.insertInt | ifFault;
    pipe[0].cs   = st.insertInt ? CAUSE_INT :
                   ifFault      ? CAUSE_IFETCH : CAUSE_NONE;
    pipe[0].slot = brInId | st.useAlt;
    pipe[0].pc   = fetchPc;
    pipe[0].alt  = st.useAlt ? epcNext :
                   brTake    ? idTarget : seqPc;
  end

  // one register per stage; the fault that a stage can raise is merged
  // as the record leaves that stage
  for (genvar s = 1; s <= NST; s++) begin : g_stage
    localparam cause_e SRC_CAUSE = (s - 1 == EX_S)  ? CAUSE_ARITH :
                                   (s - 1 == MEM_S) ? CAUSE_DATA  : CAUSE_NONE;
    logic   newFault;
    stage_t r;

    if (s - 1 == EX_S) begin : g_ex
      assign newFault = exFault & pipe[s-1].vld;
    end else if (s - 1 == MEM_S) begin : g_mem
      assign newFault = memFault & pipe[s-1].vld;
    end else begin : g_none
      assign newFault = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (!rstN || st.flush) begin
        r <= '0;
      end else begin
        r.vld  <= pipe[s-1].vld;
        r.flt  <= pipe[s-1].flt | newFault;
        r.cs   <= pipe[s-1].flt ? pipe[s-1].cs :
                  newFault      ? SRC_CAUSE    : CAUSE_NONE;
        r.slot <= pipe[s-1].slot;
        r.pc   <= pipe[s-1].pc;
        r.alt  <= pipe[s-1].alt;
      end
    end

    assign pipe[s] = r;
  end

  always_comb begin
    if (st.takeTrap)     nextPc = VEC_PC;
    else if (st.takeRet) nextPc = epc;
    else if (st.useAlt)  nextPc = epcNext;
    else if (brTake)     nextPc = idTarget;
    else                 nextPc = seqPc;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fetchPc  <= RST_PC;
      epc      <= '0;
      epcNext  <= '0;
      epcSlot  <= 1'b0;
      excCause <= CAUSE_NONE;
    end else begin
      fetchPc <= nextPc;
      if (st.takeTrap) begin
        epc      <= pipe[WB_S].pc;
        epcNext  <= pipe[WB_S].alt;
        epcSlot  <= pipe[WB_S].slot;
        excCause <= pipe[WB_S].cs;
      end
    end
  end

  assign wbValid    = pipe[WB_S].vld;
  assign wbFault    = pipe[WB_S].flt;
  assign wbPc       = pipe[WB_S].pc;
  assign wbCommit   = pipe[WB_S].vld & ~pipe[WB_S].flt;
  assign memWriteOk = pipe[MEM_S].vld & ~pipe[MEM_S].flt & ~memFault & ~st.flush;

endmodule

// File: rtl/precise_exc_commit.sv
module precise_exc_commit
  import pexc_pkg::*;
#(
  parameter int unsigned PC_W       = 32,
  parameter int unsigned INSN_BYTES = 4,
  parameter int unsigned VECTOR     = 32'h0000_0180,
  parameter int unsigned RESET_PC   = 32'h0000_1000
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            ifFault,
  input  logic            exFault,
  input  logic            memFault,
  input  logic            intReq,
  input  logic            eret,
  input  logic            idBranch,
  input  logic            idTaken,
  input  logic [PC_W-1:0] idTarget,
  output logic [PC_W-1:0] fetchPc,
  output logic            wbCommit,
  output logic [PC_W-1:0] wbPc,
  output logic            memWriteOk,
  output logic            trap,
  output logic [PC_W-1:0] epc,
  output logic [PC_W-1:0] epcNext,
  output logic            epcSlot,
  output logic [2:0]      excCause,
  output logic            superMode
);

  strobe_t st;
  logic    wbValid;
  logic    wbFault;
  cause_e  causeQ;

  pexc_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wbValid   (wbValid),
    .wbFault   (wbFault),
    .intReq    (intReq),
    .eret      (eret),
    .epcSlot   (epcSlot),
    .st        (st),
    .superMode (superMode)
  );

  pexc_dp #(
    .PC_W       (PC_W),
    .INSN_BYTES (INSN_BYTES),
    .VECTOR     (VECTOR),
    .RESET_PC   (RESET_PC)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .st         (st),
    .ifFault    (ifFault),
    .exFault    (exFault),
    .memFault   (memFault),
    .idBranch   (idBranch),
    .idTaken    (idTaken),
    .idTarget   (idTarget),
    .fetchPc    (fetchPc),
    .wbValid    (wbValid),
    .wbFault    (wbFault),
    .wbPc       (wbPc),
    .wbCommit   (wbCommit),
    .memWriteOk (memWriteOk),
    .epc        (epc),
    .epcNext    (epcNext),
    .epcSlot    (epcSlot),
    .excCause   (causeQ)
  );

  assign trap     = st.takeTrap;
  assign excCause = causeQ;

endmodule

// File: rtl/precise_exc_commit_chk.sv
module precise_exc_commit_chk #(
  parameter int unsigned PC_W   = 32,
  parameter int unsigned VECTOR = 32'h0000_0180
) (
  input logic            clk,
  input logic            rstN,
  input logic            eret,
  input logic [PC_W-1:0] fetchPc,
  input logic            wbCommit,
  input logic [PC_W-1:0] wbPc,
  input logic            memWriteOk,
  input logic            trap,
  input logic [PC_W-1:0] epc,
  input logic            superMode
);

  // R4: trap vectors fetch and enters supervisor mode
  p_trap_vector_r4: assert property (@(posedge clk) disable iff (!rstN)
    trap |=> (fetchPc == PC_W'(VECTOR)) && superMode);

  // R4: saved PC is the trapping instruction's PC
  p_trap_epc_r4: assert property (@(posedge clk) disable iff (!rstN)
    trap |=> epc == $past(wbPc));

  // R5: faulting instruction does not commit
  p_no_commit_on_trap_r5: assert property (@(posedge clk) disable iff (!rstN)
    trap |-> !wbCommit);

  // R5: younger memory-stage instruction may not write
  p_mem_blocked_r5: assert property (@(posedge clk) disable iff (!rstN)
    trap |-> !memWriteOk);

  // R6: nothing commits the cycle after a trap
  p_squash_r6: assert property (@(posedge clk) disable iff (!rstN)
    trap |=> !wbCommit);

  // R12: return restarts at epc and leaves supervisor mode
  p_return_r12: assert property (@(posedge clk) disable iff (!rstN)
    (eret && superMode && !trap) |=> (fetchPc == $past(epc)) && !superMode);

  // R12: return in user mode leaves the mode untouched
  p_user_return_r12: assert property (@(posedge clk) disable iff (!rstN)
    (eret && !superMode && !trap) |=> !superMode);

endmodule

bind precise_exc_commit precise_exc_commit_chk #(
  .PC_W   (PC_W),
  .VECTOR (VECTOR)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .eret       (eret),
  .fetchPc    (fetchPc),
  .wbCommit   (wbCommit),
  .wbPc       (wbPc),
  .memWriteOk (memWriteOk),
  .trap       (trap),
  .epc        (epc),
  .superMode  (superMode)
);

// File: tb/precise_exc_commit_tb.sv
module precise_exc_commit_tb;

  localparam int          CLK_PERIOD = 10;
  localparam int unsigned PW         = 32;
  localparam logic [31:0] VEC        = 32'h0000_0180;
  localparam logic [31:0] RSTPC      = 32'h0000_1000;

  logic          clk = 1'b0;
  logic          rstN;
  logic          ifFault, exFault, memFault, intReq, eret, idBranch, idTaken;
  logic [PW-1:0] idTarget;
  logic [PW-1:0] fetchPc, wbPc, epc, epcNext;
  logic          wbCommit, memWriteOk, trap, epcSlot, superMode;
  logic [2:0]    excCause;

  always #(CLK_PERIOD/2) clk = ~clk;

  precise_exc_commit #(
    .PC_W(PW), .INSN_BYTES(4), .VECTOR(VEC), .RESET_PC(RSTPC)
  ) u_dut (
    .clk(clk), .rstN(rstN), .ifFault(ifFault), .exFault(exFault),
    .memFault(memFault), .intReq(intReq), .eret(eret), .idBranch(idBranch),
    .idTaken(idTaken), .idTarget(idTarget), .fetchPc(fetchPc),
    .wbCommit(wbCommit), .wbPc(wbPc), .memWriteOk(memWriteOk), .trap(trap),
    .epc(epc), .epcNext(epcNext), .epcSlot(epcSlot), .excCause(excCause),
    .superMode(superMode)
  );

  typedef struct {
    logic [PW-1:0] pc;
    logic [PW-1:0] nxt;
    logic          slot;
    logic [2:0]    cause;
  } trap_exp_t;

  trap_exp_t expQ[$];
  int nChecks = 0;
  int nFails  = 0;
  int trapsSeen = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [PW-1:0] act, input logic [PW-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  // driver: push an expected trap record
  task automatic pushTrap(input logic [PW-1:0] p, input logic [PW-1:0] n,
                          input logic s, input logic [2:0] c);
    trap_exp_t e;
    e.pc = p; e.nxt = n; e.slot = s; e.cause = c;
    expQ.push_back(e);
  endtask

  // enter the drive window of the next cycle; pulse inputs drop
  task automatic cyc();
    @(negedge clk);
    #2;
    ifFault = 0; exFault = 0; memFault = 0; eret = 0; idBranch = 0; idTaken = 0;
  endtask

  task automatic waitPc(input logic [PW-1:0] p);
    int n = 0;
    cyc();
    while (fetchPc !== p && n < 300) begin
      cyc();
      n++;
    end
  endtask

  task automatic doReturn(input logic [PW-1:0] first, input logic [PW-1:0] second,
                          input string req);
    cyc(); eret = 1;
    cyc(); #1;
    check(fetchPc == first, req, "restart pc", fetchPc, first);
    check(superMode == 1'b0, req, "mode after return", 32'(superMode), 32'd0);
    cyc(); #1;
    check(fetchPc == second, req, "pc after restart", fetchPc, second);
  endtask

  // monitor: on each trap compare the saved state one cycle later
  bit pend = 1'b0;
  always begin
    @(negedge clk);
    #4;
    if (rstN === 1'b1) begin
      if (pend) begin
        trap_exp_t e;
        trapsSeen++;
        if (expQ.size() == 0) begin
          check(1'b0, "R7", "unexpected trap, epc", epc, 32'hFFFF_FFFF);
        end else begin
          e = expQ.pop_front();
          check(epc == e.pc, "R4", "epc", epc, e.pc);
          check(epcNext == e.nxt, "R10", "epcNext", epcNext, e.nxt);
          check(epcSlot == e.slot, "R10", "epcSlot", 32'(epcSlot), 32'(e.slot));
          check(excCause == e.cause, "R3", "excCause", 32'(excCause), 32'(e.cause));
          check(fetchPc == VEC && superMode, "R4", "vector/mode", fetchPc, VEC);
        end
      end
      pend = (trap === 1'b1);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: run did not finish");
    summary();
  end

  initial begin
    logic [PW-1:0] a, b, c, d, q, t, p;
    rstN = 0; ifFault = 0; exFault = 0; memFault = 0; intReq = 0; eret = 0;
    idBranch = 0; idTaken = 0; idTarget = '0;

    // R1 reset state
    repeat (3) cyc();
    #1;
    check(fetchPc == RSTPC, "R1", "reset fetchPc", fetchPc, RSTPC);
    check(!superMode && !trap && !wbCommit, "R1", "reset flags",
          {superMode, trap, wbCommit}, 0);
    cyc(); rstN = 1; #1;
    check(!wbCommit, "R2", "empty pipe", 32'(wbCommit), 0);
    repeat (3) cyc();
    cyc(); #1;
    check(wbCommit && wbPc == RSTPC, "R2", "first commit", wbPc, RSTPC);
    cyc(); #1;
    check(wbCommit && wbPc == RSTPC + 4, "R2", "second commit", wbPc, RSTPC + 4);

    // R3/R4/R5/R6 arithmetic fault
    a = fetchPc + 32'h10;
    pushTrap(a, a + 4, 1'b0, 3'd3);
    waitPc(a);
    cyc(); cyc(); exFault = 1; #1;
    check(memWriteOk, "R5", "older store allowed", 32'(memWriteOk), 1);
    cyc(); #1;
    check(!memWriteOk, "R5", "faulting store blocked", 32'(memWriteOk), 0);
    check(wbCommit && wbPc == a - 4, "R2", "commit before fault", wbPc, a - 4);
    cyc(); #1;
    check(trap, "R3", "trap at writeback", 32'(trap), 1);
    check(!wbCommit, "R5", "faulting commit", 32'(wbCommit), 0);
    check(!memWriteOk, "R5", "younger store blocked", 32'(memWriteOk), 0);
    for (int i = 1; i <= 4; i++) begin
      cyc(); #1;
      check(!wbCommit, "R6", "squash window", wbPc, 0);
    end
    cyc(); #1;
    check(wbCommit && wbPc == VEC, "R6", "handler commit", wbPc, VEC);
    doReturn(a, a + 4, "R12");

    // R7 younger fault raised first, older wins
    b = fetchPc + 32'h10;
    pushTrap(b, b + 4, 1'b0, 3'd4);
    waitPc(b);
    cyc(); cyc(); ifFault = 1;
    cyc(); memFault = 1;
    cyc(); #1;
    check(trap, "R7", "oldest trap", 32'(trap), 1);
    repeat (5) cyc();
    doReturn(b, b + 4, "R12");
    repeat (10) cyc();
    #1;
    check(trapsSeen == 2, "R7", "trap count", trapsSeen, 2);

    // R8 two faults on one instruction
    c = fetchPc + 32'h10;
    pushTrap(c, c + 4, 1'b0, 3'd2);
    waitPc(c);
    ifFault = 1;
    cyc(); cyc(); exFault = 1;
    cyc(); cyc(); #1;
    check(trap, "R8", "trap for double fault", 32'(trap), 1);
    repeat (5) cyc();
    doReturn(c, c + 4, "R12");

    // R9 interrupt as faulting no-op, masked in supervisor
    d = fetchPc + 32'h10;
    pushTrap(d, d + 4, 1'b0, 3'd1);
    waitPc(d);
    intReq = 1;
    repeat (4) cyc();
    #1;
    check(trap, "R9", "interrupt trap", 32'(trap), 1);
    repeat (8) cyc();
    #1;
    check(superMode && trapsSeen == 4, "R9", "masked in supervisor", trapsSeen, 4);
    intReq = 0;
    doReturn(d, d + 4, "R12");

    // R10/R11 interrupt on delay slot of taken branch
    q = fetchPc + 32'h10;
    t = q + 32'h200;
    pushTrap(q + 4, t, 1'b1, 3'd1);
    waitPc(q);
    cyc(); idBranch = 1; idTaken = 1; idTarget = t; intReq = 1;
    cyc(); intReq = 0; #1;
    check(fetchPc == t, "R11", "taken redirect", fetchPc, t);
    repeat (3) cyc();
    #1;
    check(trap, "R10", "slot trap", 32'(trap), 1);
    repeat (5) cyc();
    doReturn(q + 4, t, "R10");

    // R10/R11 fetch fault on slot of not-taken branch
    q = fetchPc + 32'h10;
    pushTrap(q + 4, q + 8, 1'b1, 3'd2);
    waitPc(q);
    cyc(); idBranch = 1; idTaken = 0; idTarget = q + 32'h300; ifFault = 1;
    cyc(); #1;
    check(fetchPc == q + 8, "R11", "not-taken sequence", fetchPc, q + 8);
    repeat (3) cyc();
    #1;
    check(trap, "R10", "slot fault trap", 32'(trap), 1);
    repeat (5) cyc();
    doReturn(q + 4, q + 8, "R10");

    // R12 return in user mode ignored
    cyc();
    p = fetchPc;
    eret = 1;
    cyc(); #1;
    check(fetchPc == p + 4 && !superMode, "R12", "user-mode return", fetchPc, p + 4);

    repeat (8) cyc();
    #1;
    check(trapsSeen == 6 && expQ.size() == 0, "R7", "all traps seen", trapsSeen, 6);
    summary();
  end

endmodule